// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when the analog-to-digital converter begins a conversion sequence and when that sequence is over. A two-bit mode field picks one of three start sources: a pulse from a timer overflow, a software write that starts at once, or a chosen edge on an external input pin. When a start is accepted the block issues a one-clock start pulse to the converter sequencer. It then holds a busy flag until the converter returns a done pulse. While busy, further timer and pin triggers are thrown away, not saved for later.

Writing the mode field to its stop value halts the sequence. It clears the busy flag and disarms the block. A disarmed block accepts no start from any source until software writes the channel-select register. That write reloads the input multiplexer pointer to the first selected channel, and the block signals the reload to the multiplexer with a one-cycle pulse. The external pin is asynchronous, so it passes through a synchronizer chain before edge detection.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, `conv_start`, `conv_busy` and `ptr_reload` are 0, `armed` is 1 and the stored mode is stop.
- R2: When `mode_we` is high, `mode_val` is loaded as the start mode. The encoding is 2'b00 stop, 2'b01 timer, 2'b10 immediate and 2'b11 pin edge.
- R3: In timer mode with `tmr_en` = 1, a `tmr_ovf` pulse seen at a clock edge while the block is idle and armed raises `conv_start` right after that edge. With `tmr_en` = 0 the overflow has no effect.
- R4: A write of the immediate code, while idle and armed, raises `conv_start` right after the write edge. No other event is needed.
- R5: In edge mode, `edge_fall` = 0 selects rising edges and 1 selects falling edges of `ext_pin`. A selected edge placed before clock edge k raises `conv_start` right after edge k+2, because of the two synchronizer stages. An edge of the other polarity starts nothing.
- R6: While `conv_busy` is 1, timer, pin and immediate triggers are dropped. Once done has arrived, no start follows unless there is a new trigger.
- R7: `conv_start` lasts one clock and `conv_busy` rises with it. `conv_done` clears `conv_busy`. A done pulse while idle changes nothing.
- R8: A stop write clears `conv_busy` and `armed`. A trigger in the same cycle as the stop write produces no start.
- R9: While `armed` is 0, no source can start a conversion. `chsel_we` sets `armed` and raises `ptr_reload` for exactly one clock after its edge.
- R10: A pin held at a constant level after one transition produces only one start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the start-mode field |
| mode_val | input | 2 | Start-mode value to write |
| tmr_en | input | 1 | Timer-mode enable bit |
| edge_fall | input | 1 | Edge select: 0 rising, 1 falling |
| chsel_we | input | 1 | Channel-select register write strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| conv_done | input | 1 | Converter completion pulse |
| conv_start | output | 1 | One-clock start pulse to the sequencer |
| conv_busy | output | 1 | Conversion in progress |
| armed | output | 1 | Channel pointer valid; starts allowed |
| ptr_reload | output | 1 | Pulse that reloads the multiplexer pointer to the first channel |

## Verification
The hardest states to reach from the ports are a stop write landing in the same cycle as a live trigger, and a disarmed block that already holds a valid start mode. The bench reaches the first by raising a timer overflow in the cycle that writes the stop code. It reaches the second by writing the timer mode again before any channel-select write, then offering both an overflow and an immediate write. Pin timing is checked by counting clock edges from a pin change and expecting the pulse only on the third edge.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_TMR  = 2'b01,
    MODE_IMM  = 2'b10,
    MODE_EDGE = 2'b11
  } start_mode_e;

  // True when the synchronized pin moved in the selected direction
  function automatic logic edge_seen(input logic prev, input logic cur, input logic fall);
    logic rose, fell;
    rose = cur & ~prev;
    fell = prev & ~cur;
    return fall ? fell : rose;
  endfunction

  // A mode write that carries the stop code
  function automatic logic is_stop(input logic we, input logic [1:0] val);
    return we && (start_mode_e'(val) == MODE_OFF);
  endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic sel_fall,
  output logic edge_evt
);
  import adc_start_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur_lvl  = sync_q[SYNC_STAGES-1];
  assign edge_evt = edge_seen(prev_q, cur_lvl, sel_fall);

  // R10
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && $stable(sel_fall) |=> !edge_evt);

endmodule

// File: rtl/adc_trig_mux.sv
module adc_trig_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_val,
  input  logic       tmr_en,
  input  logic       tmr_ovf,
  input  logic       edge_evt,
  output logic       trig,
  output logic       stop_req
);
  import adc_start_pkg::*;

  start_mode_e mode_q;
  logic        tmr_hit, imm_hit, pin_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_we) mode_q <= start_mode_e'(mode_val);
  end

  assign tmr_hit  = (mode_q == MODE_TMR) && tmr_en && tmr_ovf;
  assign pin_hit  = (mode_q == MODE_EDGE) && edge_evt;
  assign imm_hit  = mode_we && (start_mode_e'(mode_val) == MODE_IMM);
  assign trig     = tmr_hit | pin_hit | imm_hit;
  assign stop_req = is_stop(mode_we, mode_val);

  // R3
  tmr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TMR) && !tmr_en && !mode_we |-> !trig);

  // R2
  stop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (mode_q == MODE_OFF));

endmodule

// File: rtl/adc_run_ctrl.sv
module adc_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic stop_req,
  input  logic chsel_we,
  input  logic conv_done,
  output logic conv_start,
  output logic conv_busy,
  output logic armed,
  output logic ptr_reload
);

  logic go;

  assign go = trig && !conv_busy && armed && !stop_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      conv_busy  <= 1'b0;
      armed      <= 1'b1;
      ptr_reload <= 1'b0;
    end else begin
      conv_start <= go;
      ptr_reload <= chsel_we;
      if (stop_req)       conv_busy <= 1'b0;
      else if (go)        conv_busy <= 1'b1;
      else if (conv_done) conv_busy <= 1'b0;
      if (stop_req)       armed <= 1'b0;
      else if (chsel_we)  armed <= 1'b1;
    end
  end

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_busy);

  // R6
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !conv_start);

  // R8
  stop_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !conv_start && !conv_busy && !armed);

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chsel_we && !stop_req |=> armed && ptr_reload);

  // R9
  disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !conv_start);

endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_val,
  input  logic       tmr_en,
  input  logic       edge_fall,
  input  logic       chsel_we,
  input  logic       tmr_ovf,
  input  logic       ext_pin,
  input  logic       conv_done,
  output logic       conv_start,
  output logic       conv_busy,
  output logic       armed,
  output logic       ptr_reload
);

  logic edge_evt;
  logic trig;
  logic stop_req;

  adc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .sel_fall  (edge_fall),
    .edge_evt  (edge_evt)
  );

  adc_trig_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (mode_we),
    .mode_val (mode_val),
    .tmr_en   (tmr_en),
    .tmr_ovf  (tmr_ovf),
    .edge_evt (edge_evt),
    .trig     (trig),
    .stop_req (stop_req)
  );

  adc_run_ctrl u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .stop_req   (stop_req),
    .chsel_we   (chsel_we),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_busy  (conv_busy),
    .armed      (armed),
    .ptr_reload (ptr_reload)
  );

endmodule

// File: tb/test_adc_start_ctrl.sv
module test_adc_start_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_we = 1'b0;
  logic [1:0] mode_val = 2'b00;
  logic       tmr_en = 1'b0, edge_fall = 1'b0, chsel_we = 1'b0;
  logic       tmr_ovf = 1'b0, ext_pin = 1'b0, conv_done = 1'b0;
  logic       conv_start, conv_busy, armed, ptr_reload;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  adc_start_ctrl i_adc_start_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .tmr_en(tmr_en), .edge_fall(edge_fall), .chsel_we(chsel_we),
    .tmr_ovf(tmr_ovf), .ext_pin(ext_pin), .conv_done(conv_done),
    .conv_start(conv_start), .conv_busy(conv_busy), .armed(armed),
    .ptr_reload(ptr_reload)
  );

  // {tmr_ovf, conv_done, expected start, expected busy}, timer mode, armed
  localparam logic [3:0] VEC [0:8] = '{
    4'b0000, 4'b1011, 4'b1001, 4'b0001, 4'b0100,
    4'b1111, 4'b1100, 4'b1011, 4'b0100
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic write_mode(logic [1:0] v);
    mode_we = 1'b1; mode_val = v;
    tick();
    mode_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "start", conv_start, 1'b0);
    check("R1", "busy", conv_busy, 1'b0);
    check("R1", "armed", armed, 1'b1);
    check("R1", "reload", ptr_reload, 1'b0);
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    check("R2", "no start in stop mode", conv_start, 1'b0);

    // R2 R3 timer mode vector walk
    tmr_en = 1'b1;
    write_mode(2'b01);
    for (int i = 0; i < 9; i++) begin
      tmr_ovf = VEC[i][3]; conv_done = VEC[i][2];
      tick();
      check("R3", $sformatf("row%0d start", i), conv_start, VEC[i][1]);
      check("R7", $sformatf("row%0d busy", i), conv_busy, VEC[i][0]);
    end
    tmr_ovf = 1'b0; conv_done = 1'b0;

    // R3 timer enable cleared
    tmr_en = 1'b0; tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    check("R3", "ovf with enable off", conv_start, 1'b0);
    tmr_en = 1'b1;

    // R4 immediate start
    write_mode(2'b10);
    check("R4", "immediate start", conv_start, 1'b1);
    check("R4", "immediate busy", conv_busy, 1'b1);
    tick();
    check("R7", "single pulse", conv_start, 1'b0);
    write_mode(2'b10);
    check("R6", "immediate while busy", conv_start, 1'b0);
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    check("R7", "done clears busy", conv_busy, 1'b0);
    tick();
    check("R6", "no queued start", conv_start, 1'b0);

    // R5 rising edge
    edge_fall = 1'b0;
    write_mode(2'b11);
    ext_pin = 1'b1;
    tick(); check("R5", "rise k", conv_start, 1'b0);
    tick(); check("R5", "rise k+1", conv_start, 1'b0);
    tick(); check("R5", "rise k+2", conv_start, 1'b1);
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(); check("R10", "held high", conv_start, 1'b0);
    end
    // R5 falling edge
    edge_fall = 1'b1; ext_pin = 1'b0;
    tick(); check("R5", "fall k", conv_start, 1'b0);
    tick(); check("R5", "fall k+1", conv_start, 1'b0);
    tick(); check("R5", "fall k+2", conv_start, 1'b1);
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    ext_pin = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(); check("R5", "wrong polarity", conv_start, 1'b0);
    end

    // R8 stop with trigger in same cycle
    write_mode(2'b01);
    tmr_ovf = 1'b1; mode_we = 1'b1; mode_val = 2'b00;
    tick();
    tmr_ovf = 1'b0; mode_we = 1'b0;
    check("R8", "stop beats trigger", conv_start, 1'b0);
    check("R8", "stop disarms", armed, 1'b0);

    // R9 disarmed block ignores sources
    write_mode(2'b01);
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    check("R9", "ovf disarmed", conv_start, 1'b0);
    write_mode(2'b10);
    check("R9", "immediate disarmed", conv_start, 1'b0);
    chsel_we = 1'b1; tick(); chsel_we = 1'b0;
    check("R9", "rearm", armed, 1'b1);
    check("R9", "reload pulse", ptr_reload, 1'b1);
    tick();
    check("R9", "reload one cycle", ptr_reload, 1'b0);
    write_mode(2'b01);
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    check("R9", "start after rearm", conv_start, 1'b1);

    // R8 stop aborts running conversion
    write_mode(2'b00);
    check("R8", "stop clears busy", conv_busy, 1'b0);
    check("R8", "no start on stop", conv_start, 1'b0);

    finish_run();
  end

endmodule